// File: doc/BRIEF.md
# Variable-Length Message Receive FIFO

This block holds received bus messages of varying size in a 64-byte circular byte store and gives them back in arrival order. The receive path offers one complete message per cycle. That message is a frame-info byte plus up to twelve body bytes, holding the identifier first and then the payload. The block works out the message length from the frame-info byte. It stores exactly that many bytes, but only when the whole message fits in the free space.

The consumer sees a fixed window of thirteen bytes. The window always begins at the first byte of the oldest stored message, with the frame-info byte at offset 0. Every offered message is counted, and the counter saturates at 64. A message that does not fit is still counted, but it leaves only an overrun placeholder behind. A release strobe removes the oldest counted entry, whether it holds data or is a placeholder, and the window then moves on. A sticky overrun flag records that data was lost. It stays set until the count drains to zero.

Top module: `rx_msg_fifo`

## Requirements
- R1: After synchronous reset, `msg_count` is 0, `overrun` is 0 and `head_valid` is 0.
- R2: Frame-info encoding is as follows. Bit 7 set means the extended format with a 5-byte header, and clear means the standard format with a 3-byte header. Bit 6 set means a remote frame with no payload. Bits 3:0 are the DLC, and the payload is min(DLC, 8) bytes. A stored message occupies header + payload bytes. In the window, byte 0 is the frame-info byte and byte k (k >= 1) is body byte k-1, where body byte j is `wr_body[8j+7:8j]`.
- R3: The window shows the bytes of the oldest stored message. They stay unchanged until a release, and after a release the window shows the next stored message.
- R4: A message is stored only if its length is at most 64 minus the bytes held by stored messages. Otherwise it is counted as an overrun placeholder. `head_valid` is 1 exactly when the count is nonzero and the oldest counted entry holds data.
- R5: Each offered message raises `msg_count` by one, up to 64. A message offered at count 64 with no release in the same cycle is neither stored nor counted.
- R6: A release lowers `msg_count` by one. It frees the bytes of the oldest entry if that entry holds data, and frees no bytes if the entry is a placeholder.
- R7: A release while `msg_count` is 0 has no effect.
- R8: `overrun` rises in the cycle after any message is dropped. It returns to 0 when `msg_count` reaches 0.
- R9: When a write and a release fall in the same cycle, the write is checked for room against the space held before the release. `msg_count` stays the same, because the release always makes room in the count.
- R10: Byte positions wrap modulo 64. A message that straddles the end of the store reads back intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Offers one complete message this cycle |
| wr_info | input | 8 | Frame-info byte of the offered message |
| wr_body | input | 96 | Identifier and payload bytes, body byte j at bits 8j+7:8j |
| rel | input | 1 | Release the oldest counted entry |
| win | output | 104 | Read window: byte k at bits 8k+7:8k, starting at the oldest stored message |
| head_valid | output | 1 | Oldest counted entry holds data shown in the window |
| msg_count | output | 7 | Counted entries, saturating at 64 |
| overrun | output | 1 | A message was dropped since the count was last zero |

## Verification
A message offer and a release can land in the same clock edge. The bench provokes this in three states. The first has the store full to the last byte, so the offer must be dropped even though the release frees room. The second has plenty of room, so the offer is stored behind the message being popped. The third has the count saturated at 64, so the offer is counted only because the release makes room. In each case the bench compares the count, the overrun flag, `head_valid` and the window bytes with a reference queue. That queue judges room before the release and counts after it.

// File: rtl/rx_msg_fifo_pkg.sv
package rx_msg_fifo_pkg;

    // Frame-info byte layout
    localparam int FI_EXT_BIT  = 7;
    localparam int FI_RTR_BIT  = 6;
    localparam int FI_DLC_LSB  = 0;
    localparam int FI_DLC_W    = 4;

    localparam int HDR_STD_BYTES   = 3;
    localparam int HDR_EXT_BYTES   = 5;
    localparam int PAYLOAD_MAX     = 8;
    localparam int MSG_MAX_BYTES   = HDR_EXT_BYTES + PAYLOAD_MAX;
    localparam int MSG_BODY_BYTES  = MSG_MAX_BYTES - 1;
    localparam int MSG_LEN_W       = $clog2(MSG_MAX_BYTES + 1);

    typedef enum logic {
        ENT_DROPPED = 1'b0,
        ENT_STORED  = 1'b1
    } entry_kind_t;

    // Bytes occupied by a message: header plus clamped payload
    function automatic logic [MSG_LEN_W-1:0] msg_len(
        input logic                ext,
        input logic                rtr,
        input logic [FI_DLC_W-1:0] dlc
    );
        logic [MSG_LEN_W-1:0] hdr;
        logic [MSG_LEN_W-1:0] pay;
        hdr = ext ? MSG_LEN_W'(HDR_EXT_BYTES) : MSG_LEN_W'(HDR_STD_BYTES);
        if (rtr)
            pay = '0;
        else if (dlc > FI_DLC_W'(PAYLOAD_MAX))
            pay = MSG_LEN_W'(PAYLOAD_MAX);
        else
            pay = MSG_LEN_W'(dlc);
        return hdr + pay;
    endfunction

endpackage

// File: rtl/rx_msg_len.sv
module rx_msg_len
    import rx_msg_fifo_pkg::*;
(
    input  logic                 ext,
    input  logic                 rtr,
    input  logic [FI_DLC_W-1:0]  dlc,
    output logic [MSG_LEN_W-1:0] len
);

    always_comb len = msg_len(ext, rtr, dlc);

endmodule

// File: rtl/rx_byte_store.sv
module rx_byte_store
    import rx_msg_fifo_pkg::*;
#(
    parameter  int DEPTH  = 64,              // power of two
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int USED_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [MSG_LEN_W-1:0]          wr_len,
    input  logic [7:0]                    wr_info,
    input  logic [MSG_BODY_BYTES*8-1:0]   wr_body,
    input  logic                          rd_en,
    input  logic [MSG_LEN_W-1:0]          rd_len,
    output logic [MSG_MAX_BYTES*8-1:0]    win,
    output logic [USED_W-1:0]             used
);

    logic [7:0]        mem [DEPTH];
    logic [PTR_W-1:0]  hd_ptr;
    logic [PTR_W-1:0]  tl_ptr;
    logic [MSG_MAX_BYTES*8-1:0] msg_bytes;

    assign msg_bytes = {wr_body, wr_info};

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_ptr <= '0;
            tl_ptr <= '0;
            used   <= '0;
        end else begin
            for (int k = 0; k < MSG_MAX_BYTES; k++) begin
                if (wr_en && (MSG_LEN_W'(k) < wr_len))
                    mem[tl_ptr + PTR_W'(k)] <= msg_bytes[k*8 +: 8];
            end
            if (wr_en) tl_ptr <= tl_ptr + PTR_W'(wr_len);
            if (rd_en) hd_ptr <= hd_ptr + PTR_W'(rd_len);
            used <= used + (wr_en ? USED_W'(wr_len) : '0)
                         - (rd_en ? USED_W'(rd_len) : '0);
        end
    end

    always_comb begin
        for (int k = 0; k < MSG_MAX_BYTES; k++)
            win[k*8 +: 8] = mem[hd_ptr + PTR_W'(k)];
    end

    // R4
    used_bound_chk: assert property (@(posedge clk) disable iff (rst)
        used <= USED_W'(DEPTH));

    // R6
    rd_cover_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> used >= USED_W'(rd_len));

endmodule

// File: rtl/rx_entry_tracker.sv
module rx_entry_tracker
    import rx_msg_fifo_pkg::*;
#(
    parameter  int MAX_MSGS = 64,
    localparam int CNT_W    = $clog2(MAX_MSGS + 1),
    localparam int ENT_W    = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             push_fits,
    input  logic             pop_req,
    output logic             store_go,
    output logic             pop_stored,
    output logic             head_stored,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr
);

    entry_kind_t       kind_q [MAX_MSGS];
    logic [ENT_W-1:0]  hd;
    logic [ENT_W-1:0]  tl;
    logic              pop_go;
    logic              push_go;
    logic              drop;
    logic [CNT_W-1:0]  cnt_rem;
    logic [CNT_W-1:0]  cnt_nxt;

    function automatic logic [ENT_W-1:0] ent_inc(input logic [ENT_W-1:0] p);
        return (p == ENT_W'(MAX_MSGS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_go      = pop_req && (cnt != '0);
        cnt_rem     = cnt - CNT_W'(pop_go);
        push_go     = push_req && (cnt_rem < CNT_W'(MAX_MSGS));
        store_go    = push_go && push_fits;
        head_stored = (cnt != '0) && (kind_q[hd] == ENT_STORED);
        pop_stored  = pop_go && head_stored;
        drop        = push_req && !store_go;
        cnt_nxt     = cnt_rem + CNT_W'(push_go);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hd  <= '0;
            tl  <= '0;
            cnt <= '0;
            ovr <= 1'b0;
            for (int i = 0; i < MAX_MSGS; i++) kind_q[i] <= ENT_DROPPED;
        end else begin
            if (push_go) begin
                kind_q[tl] <= store_go ? ENT_STORED : ENT_DROPPED;
                tl         <= ent_inc(tl);
            end
            if (pop_go) hd <= ent_inc(hd);
            cnt <= cnt_nxt;
            ovr <= (cnt_nxt == '0) ? 1'b0 : (ovr | drop);
        end
    end

    // R5
    cnt_max_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_MSGS));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && cnt < CNT_W'(MAX_MSGS)) |=> cnt == $past(cnt) + 1'b1);

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && cnt == CNT_W'(MAX_MSGS)) |=> cnt == CNT_W'(MAX_MSGS));

    // R7
    rel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && cnt == '0) |=> cnt == '0);

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !ovr);

    // R9
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && cnt != '0) |=> cnt == $past(cnt));

endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
    import rx_msg_fifo_pkg::*;
#(
    parameter  int DEPTH_BYTES = 64,
    parameter  int MAX_MSGS    = 64,
    localparam int CNT_W       = $clog2(MAX_MSGS + 1),
    localparam int USED_W      = $clog2(DEPTH_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_valid,
    input  logic [7:0]                  wr_info,
    input  logic [MSG_BODY_BYTES*8-1:0] wr_body,
    input  logic                        rel,
    output logic [MSG_MAX_BYTES*8-1:0]  win,
    output logic                        head_valid,
    output logic [CNT_W-1:0]            msg_count,
    output logic                        overrun
);

    logic [MSG_LEN_W-1:0] wr_len;
    logic [MSG_LEN_W-1:0] hd_len;
    logic [USED_W-1:0]    used;
    logic [USED_W-1:0]    free_bytes;
    logic                 fits;
    logic                 store_go;
    logic                 pop_stored;

    rx_msg_len u_wr_len (
        .ext (wr_info[FI_EXT_BIT]),
        .rtr (wr_info[FI_RTR_BIT]),
        .dlc (wr_info[FI_DLC_LSB +: FI_DLC_W]),
        .len (wr_len)
    );

    rx_msg_len u_hd_len (
        .ext (win[FI_EXT_BIT]),
        .rtr (win[FI_RTR_BIT]),
        .dlc (win[FI_DLC_LSB +: FI_DLC_W]),
        .len (hd_len)
    );

    always_comb begin
        free_bytes = USED_W'(DEPTH_BYTES) - used;
        fits       = USED_W'(wr_len) <= free_bytes;
    end

    rx_entry_tracker #(.MAX_MSGS(MAX_MSGS)) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .push_req    (wr_valid),
        .push_fits   (fits),
        .pop_req     (rel),
        .store_go    (store_go),
        .pop_stored  (pop_stored),
        .head_stored (head_valid),
        .cnt         (msg_count),
        .ovr         (overrun)
    );

    rx_byte_store #(.DEPTH(DEPTH_BYTES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_go),
        .wr_len  (wr_len),
        .wr_info (wr_info),
        .wr_body (wr_body),
        .rd_en   (pop_stored),
        .rd_len  (hd_len),
        .win     (win),
        .used    (used)
    );

    // R4
    no_room_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !fits) |=> overrun);

    // R3
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rel && head_valid) |=> $stable(win[7:0]) && head_valid);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (msg_count == '0) && !overrun && !head_valid);

endmodule

// File: tb/test_rx_msg_fifo.sv
`timescale 1ns/1ps
module test_rx_msg_fifo;
    import rx_msg_fifo_pkg::*;

    localparam int NB = MSG_MAX_BYTES;
    localparam int NV = 27;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        wr_valid = 1'b0;
    logic [7:0]                  wr_info = '0;
    logic [MSG_BODY_BYTES*8-1:0] wr_body = '0;
    logic                        rel = 1'b0;
    logic [NB*8-1:0]             win;
    logic                        head_valid;
    logic [6:0]                  msg_count;
    logic                        overrun;

    rx_msg_fifo i_rx_msg_fifo (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_info(wr_info),
        .wr_body(wr_body), .rel(rel), .win(win), .head_valid(head_valid),
        .msg_count(msg_count), .overrun(overrun)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic            v;
        logic [3:0]      len;
        logic [NB*8-1:0] b;
    } ment_t;
    ment_t mq[$];
    int    m_used = 0;

    // op: bit0 offer a message, bit1 release
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] info;
        logic [7:0] seed;
        logic [6:0] cnt;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h88, 8'h00, 7'd1},   // ext, 8 bytes: 13
        '{2'd1, 8'h08, 8'h10, 7'd2},   // std, 8 bytes: 11
        '{2'd1, 8'h0F, 8'h20, 7'd3},   // DLC 15 clamps: 11
        '{2'd1, 8'h48, 8'h30, 7'd4},   // remote: 3
        '{2'd1, 8'h88, 8'h40, 7'd5},
        '{2'd1, 8'h88, 8'h50, 7'd6},   // fills to exactly 64
        '{2'd1, 8'h48, 8'h60, 7'd7},   // no room: placeholder
        '{2'd2, 8'h00, 8'h00, 7'd6},
        '{2'd1, 8'h88, 8'h70, 7'd7},
        '{2'd3, 8'h08, 8'h80, 7'd7},   // room judged before release: dropped
        '{2'd2, 8'h00, 8'h00, 7'd6},
        '{2'd2, 8'h00, 8'h00, 7'd5},
        '{2'd2, 8'h00, 8'h00, 7'd4},
        '{2'd2, 8'h00, 8'h00, 7'd3},
        '{2'd2, 8'h00, 8'h00, 7'd2},   // pops placeholder
        '{2'd2, 8'h00, 8'h00, 7'd1},
        '{2'd2, 8'h00, 8'h00, 7'd0},
        '{2'd2, 8'h00, 8'h00, 7'd0},   // release at zero
        '{2'd1, 8'h88, 8'h90, 7'd1},
        '{2'd1, 8'h88, 8'hA0, 7'd2},
        '{2'd1, 8'h88, 8'hB0, 7'd3},
        '{2'd2, 8'h00, 8'h00, 7'd2},
        '{2'd2, 8'h00, 8'h00, 7'd1},
        '{2'd2, 8'h00, 8'h00, 7'd0},
        '{2'd1, 8'h88, 8'hC0, 7'd1},   // straddles byte 63 to 0
        '{2'd3, 8'h80, 8'hD0, 7'd1},   // release and store together
        '{2'd2, 8'h00, 8'h00, 7'd0}
    };

    function automatic int ref_len(input logic [7:0] info);
        int hdr;
        int pay;
        hdr = info[7] ? 5 : 3;
        if (info[6])            pay = 0;
        else if (info[3:0] > 8) pay = 8;
        else                    pay = int'(info[3:0]);
        return hdr + pay;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string wtag);
        logic            hv;
        logic [NB*8-1:0] mask;
        hv = (mq.size() > 0) && mq[0].v;
        check(msg_count == 7'(mq.size()), "R5", "count",
              NB*8'(msg_count), NB*8'(mq.size()));
        check(overrun == (mq.size() > 0 && overrun_model), "R8", "overrun",
              NB*8'(overrun), NB*8'(mq.size() > 0 && overrun_model));
        check(head_valid == hv, "R4", "head_valid", NB*8'(head_valid), NB*8'(hv));
        if (hv) begin
            mask = '0;
            for (int i = 0; i < NB; i++)
                if (i < int'(mq[0].len)) mask[i*8 +: 8] = 8'hFF;
            check((win & mask) == (mq[0].b & mask), wtag, "window",
                  win & mask, mq[0].b & mask);
        end
    endtask

    bit overrun_model = 1'b0;

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input bit w, input bit r, input logic [7:0] info,
                        input logic [7:0] seed, input string wtag);
        logic [MSG_BODY_BYTES*8-1:0] body;
        int    len;
        int    free_b;
        ment_t e;
        for (int k = 0; k < MSG_BODY_BYTES; k++) body[k*8 +: 8] = seed + 8'(k);
        wr_valid = w;
        rel      = r;
        wr_info  = info;
        wr_body  = body;
        len      = ref_len(info);
        free_b   = 64 - m_used;
        if (r && mq.size() > 0) begin
            e = mq.pop_front();
            if (e.v) m_used -= int'(e.len);
        end
        if (w) begin
            if (mq.size() < 64) begin
                e.v   = (len <= free_b);
                e.len = 4'(len);
                e.b   = {body, info};
                mq.push_back(e);
                if (e.v) m_used += len;
                else     overrun_model = 1'b1;
            end else begin
                overrun_model = 1'b1;
            end
        end
        if (mq.size() == 0) overrun_model = 1'b0;
        @(negedge clk);
        wr_valid = 1'b0;
        rel      = 1'b0;
        compare(wtag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(msg_count == 0, "R1", "count after reset", NB*8'(msg_count), '0);
        check(!overrun, "R1", "overrun after reset", NB*8'(overrun), '0);
        check(!head_valid, "R1", "head_valid after reset", NB*8'(head_valid), '0);

        for (int i = 0; i < NV; i++) begin
            string t;
            if (i == 24)               t = "R10";
            else if (VECS[i].op == 2'd1) t = "R2";
            else                       t = "R3";
            step(VECS[i].op[0], VECS[i].op[1], VECS[i].info, VECS[i].seed, t);
            // R6
            check(msg_count == VECS[i].cnt, "R6", "table count",
                  NB*8'(msg_count), NB*8'(VECS[i].cnt));
        end

        // R5: fill the count with 3-byte messages until it saturates
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 8'h48, 8'(i), "R2");
        check(msg_count == 64, "R5", "saturated count", NB*8'(msg_count), NB*8'(64));
        step(1'b1, 1'b0, 8'h48, 8'hEE, "R3");
        check(msg_count == 64, "R5", "offer at saturation", NB*8'(msg_count), NB*8'(64));
        check(overrun, "R8", "overrun at saturation", NB*8'(overrun), NB*8'(1));

        // R9: offer and release together at a saturated count
        step(1'b1, 1'b1, 8'h48, 8'hF0, "R3");
        check(msg_count == 64, "R9", "count with both strobes", NB*8'(msg_count), NB*8'(64));

        for (int i = 0; i < 64; i++) step(1'b0, 1'b1, 8'h00, 8'h00, "R3");
        check(msg_count == 0, "R6", "drained count", NB*8'(msg_count), '0);
        check(!overrun, "R8", "overrun cleared at zero", NB*8'(overrun), '0);

        // R7
        step(1'b0, 1'b1, 8'h00, 8'h00, "R3");
        check(msg_count == 0 && !head_valid && !overrun, "R7", "release at zero",
              NB*8'({msg_count, head_valid, overrun}), '0);
        step(1'b1, 1'b0, 8'h02, 8'h55, "R7");
        check(msg_count == 1 && head_valid, "R7", "store after ignored release",
              NB*8'({msg_count, head_valid}), NB*8'({7'd1, 1'b1}));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule